// File: doc/BRIEF.md
# Branch Direction Predictor with Split Target Buffer

This block predicts whether a conditional branch is taken and where it goes. A table of single-bit direction entries records the last resolved outcome for each slot. The slot is chosen by the low bits of the branch address XORed with a short global history of recent outcomes. Each group of four neighbouring slots shares one confidence bit. A single wrong prediction first removes confidence. Only a second wrong prediction, made while confidence is already clear, reverses the stored direction.

Target storage is split in two. A larger direct-mapped table keeps only a small signed displacement per branch. A small direct-mapped table keeps complete target addresses for branches that jump far.

A lookup is combinational: the fetch address goes in, and the direction, a target-valid flag and the target come out in the same cycle. Resolved branches are written back through the update port one per cycle. Every update also shifts its outcome into the history register.

Top module: `bpred_top`

## Requirements
- R1: After reset every direction slot predicts not-taken (0), every confidence bit and the history register are 0, and no lookup reports a valid target.
- R2: The direction slot used by both lookup and update is `pc[5:0] XOR {2'b00, hist[3:0]}`. `pred_taken` is the stored bit of that slot.
- R3: Slots `4g` to `4g+3` share confidence bit `g` (`g = slot >> 2`). A correctly predicted update sets that bit.
- R4: A mispredicted update clears the group's confidence bit. The slot's bit is inverted only if that confidence bit was 0 before the update; otherwise the slot is kept.
- R5: Every update, taken or not, shifts its outcome into bit 0 of the history register. The older bits move up by one and the oldest bit is dropped.
- R6: On a taken update, the displacement `upd_target - upd_pc` is taken modulo 2^16. If it lies in the range -32 to +31, it is stored in the short table. That table is indexed by `pc[3:0]` and tagged with `pc[15:4]`. A hit there predicts `pc + sign-extended displacement`.
- R7: On a taken update whose displacement does not fit the 6-bit field, the full target is stored in the wide table. That table is indexed by `pc[0]` and tagged with `pc[15:1]`. A hit there predicts the stored target unchanged.
- R8: An address is held in at most one of the two tables. Writing one table invalidates a matching entry in the other. A not-taken update leaves both tables unchanged.
- R9: `pred_tgt_vld` is 1 exactly when the lookup address hits a valid, tag-matching entry in either table. When it is 0, `pred_tgt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 16 | Lookup branch address |
| pred_taken | output | 1 | Predicted direction for `lk_pc` |
| pred_tgt_vld | output | 1 | A target is known for `lk_pc` |
| pred_tgt | output | 16 | Predicted target address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 16 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | 16 | Resolved target address |

## Verification
The in-RTL assertions check the following on every cycle:
- a correct update sets its group's confidence bit;
- a wrong update clears that bit;
- the stored direction is kept when confidence was set and inverted when it was clear;
- the newest history bit equals the last outcome;
- no address hits both target tables;
- each table write evicts the matching address from the other table;
- not-taken updates leave the valid bits alone.

Some behaviour can only be seen in the bench's scenarios, which compare lookups against an arithmetic model of slots, groups and tables. These scenarios cover:
- how the history bends the index across a long sequence of mixed outcomes;
- which slots actually share a confidence bit;
- the exact boundary of the short displacement (-32 and +31 fit, +32 and -34 do not);
- the reconstructed target values.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_SHORT  = 2'd1,
    SRC_WIDE   = 2'd2
  } tgt_src_e;
endpackage

// File: rtl/bpred_dir.sv
module bpred_dir #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 4,
  parameter int GRP    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_lo,
  output logic             pred_taken,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_lo,
  input  logic             upd_taken
);
  localparam int N         = 1 << IDX_W;
  localparam int GRP_SH    = $clog2(GRP);
  localparam int GRP_IDX_W = IDX_W - GRP_SH;
  localparam int GRP_N     = 1 << GRP_IDX_W;

  logic [N-1:0]      dir_q;
  logic [GRP_N-1:0]  conf_q;
  logic [HIST_W-1:0] hist_q;

  function automatic logic [IDX_W-1:0] slot_of(input logic [IDX_W-1:0] lo,
                                               input logic [HIST_W-1:0] h);
    return lo ^ {{(IDX_W-HIST_W){1'b0}}, h};
  endfunction

  logic [IDX_W-1:0]     lk_slot, up_slot;
  logic [GRP_IDX_W-1:0] up_grp;
  logic                 up_pred, up_conf, up_miss, up_flip;

  assign lk_slot    = slot_of(lk_lo, hist_q);
  assign up_slot    = slot_of(upd_lo, hist_q);
  assign up_grp     = up_slot[IDX_W-1:GRP_SH];
  assign up_pred    = dir_q[up_slot];
  assign up_conf    = conf_q[up_grp];
  assign up_miss    = upd_valid && (up_pred != upd_taken);
  assign up_flip    = up_miss && !up_conf;
  assign pred_taken = dir_q[lk_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      conf_q <= '0;
      hist_q <= '0;
    end else if (upd_valid) begin
      if (up_flip) dir_q[up_slot] <= ~up_pred;
      conf_q[up_grp] <= !up_miss;
      hist_q         <= {hist_q[HIST_W-2:0], upd_taken};
    end
  end

  assert_conf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !up_miss) |=> conf_q[$past(up_grp)]);
  assert_conf_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    up_miss |=> !conf_q[$past(up_grp)]);
  assert_keep_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_miss && up_conf) |=> dir_q[$past(up_slot)] == $past(up_pred));
  assert_flip_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    up_flip |=> dir_q[$past(up_slot)] != $past(up_pred));
  assert_hist_new_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> hist_q[0] == $past(upd_taken));
endmodule

// File: rtl/bpred_btb.sv
module bpred_btb
  import bpred_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int NIDX_W = 4,
  parameter int WIDX_W = 1,
  parameter int OFF_W  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output tgt_src_e        src,
  output logic [PC_W-1:0] tgt,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  localparam int NN     = 1 << NIDX_W;
  localparam int WN     = 1 << WIDX_W;
  localparam int NTAG_W = PC_W - NIDX_W;
  localparam int WTAG_W = PC_W - WIDX_W;

  logic [NN-1:0]     n_vld;
  logic [NTAG_W-1:0] n_tag [NN];
  logic [OFF_W-1:0]  n_off [NN];
  logic [WN-1:0]     w_vld;
  logic [WTAG_W-1:0] w_tag [WN];
  logic [PC_W-1:0]   w_tgt [WN];

  function automatic logic [PC_W-1:0] sext(input logic [OFF_W-1:0] off);
    return {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
  endfunction

  function automatic logic fits(input logic [PC_W-1:0] d);
    return (d[PC_W-1:OFF_W-1] == '0) || (d[PC_W-1:OFF_W-1] == '1);
  endfunction

  logic [NIDX_W-1:0] lk_ni, up_ni;
  logic [WIDX_W-1:0] lk_wi, up_wi;
  logic [NTAG_W-1:0] up_ntag;
  logic [WTAG_W-1:0] up_wtag;
  logic              n_hit, w_hit, wr_en, wr_short;
  logic [PC_W-1:0]   up_disp;

  assign lk_ni    = lk_pc[NIDX_W-1:0];
  assign lk_wi    = lk_pc[WIDX_W-1:0];
  assign up_ni    = upd_pc[NIDX_W-1:0];
  assign up_wi    = upd_pc[WIDX_W-1:0];
  assign up_ntag  = upd_pc[PC_W-1:NIDX_W];
  assign up_wtag  = upd_pc[PC_W-1:WIDX_W];
  assign n_hit    = n_vld[lk_ni] && (n_tag[lk_ni] == lk_pc[PC_W-1:NIDX_W]);
  assign w_hit    = w_vld[lk_wi] && (w_tag[lk_wi] == lk_pc[PC_W-1:WIDX_W]);
  assign up_disp  = upd_target - upd_pc;
  assign wr_en    = upd_valid && upd_taken;
  assign wr_short = fits(up_disp);

  always_comb begin
    src = SRC_NONE;
    tgt = '0;
    if (n_hit) begin
      src = SRC_SHORT;
      tgt = lk_pc + sext(n_off[lk_ni]);
    end else if (w_hit) begin
      src = SRC_WIDE;
      tgt = w_tgt[lk_wi];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_vld <= '0;
      w_vld <= '0;
      for (int i = 0; i < NN; i++) begin
        n_tag[i] <= '0;
        n_off[i] <= '0;
      end
      for (int i = 0; i < WN; i++) begin
        w_tag[i] <= '0;
        w_tgt[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_short) begin
        n_vld[up_ni] <= 1'b1;
        n_tag[up_ni] <= up_ntag;
        n_off[up_ni] <= up_disp[OFF_W-1:0];
        if (w_tag[up_wi] == up_wtag) w_vld[up_wi] <= 1'b0;
      end else begin
        w_vld[up_wi] <= 1'b1;
        w_tag[up_wi] <= up_wtag;
        w_tgt[up_wi] <= upd_target;
        if (n_tag[up_ni] == up_ntag) n_vld[up_ni] <= 1'b0;
      end
    end
  end

  assert_single_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({n_hit, w_hit}));
  assert_short_evicts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_short) |=> n_vld[$past(up_ni)] &&
      !(w_vld[$past(up_wi)] && w_tag[$past(up_wi)] == $past(up_wtag)));
  assert_wide_evicts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_short) |=> w_vld[$past(up_wi)] &&
      !(n_vld[$past(up_ni)] && n_tag[$past(up_ni)] == $past(up_ntag)));
  assert_nt_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=> $stable(n_vld) && $stable(w_vld));
endmodule

// File: rtl/bpred_top.sv
module bpred_top
  import bpred_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int DIR_W   = 6,
  parameter int HIST_W  = 4,
  parameter int GRP     = 4,
  parameter int NIDX_W  = 4,
  parameter int WIDX_W  = 1,
  parameter int OFF_W   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_taken,
  output logic            pred_tgt_vld,
  output logic [PC_W-1:0] pred_tgt,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  tgt_src_e tsrc;

  bpred_dir #(.IDX_W(DIR_W), .HIST_W(HIST_W), .GRP(GRP)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .lk_lo(lk_pc[DIR_W-1:0]), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_lo(upd_pc[DIR_W-1:0]), .upd_taken(upd_taken)
  );

  bpred_btb #(.PC_W(PC_W), .NIDX_W(NIDX_W), .WIDX_W(WIDX_W), .OFF_W(OFF_W)) u_btb (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .src(tsrc), .tgt(pred_tgt),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target)
  );

  assign pred_tgt_vld = (tsrc != SRC_NONE);

  assert_no_tgt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_tgt_vld |-> pred_tgt == '0);
endmodule

// File: tb/bpred_top_bench.sv
module bpred_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [15:0] lk_pc = 0, upd_pc = 0, upd_target = 0;
  logic        upd_valid = 0, upd_taken = 0;
  logic        pred_taken, pred_tgt_vld;
  logic [15:0] pred_tgt;

  bpred_top u_bpred_top (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
    .pred_taken(pred_taken), .pred_tgt_vld(pred_tgt_vld), .pred_tgt(pred_tgt),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // arithmetic model
  bit m_dir [64];
  bit m_conf[16];
  int m_hist;
  bit m_nv [16]; int m_ntag[16]; int m_noff[16];
  bit m_wv [2];  int m_wtag[2];  int m_wtgt[2];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int slot(input int pc);
    return (pc % 64) ^ m_hist;   // R2
  endfunction

  function automatic int sdisp(input int pc, input int tg);
    int d = (tg - pc + 65536) % 65536;
    return (d >= 32768) ? d - 65536 : d;
  endfunction

  task automatic expect_lookup(input int pc, input string tag);
    int exp_v = 0, exp_t = 0;
    int ni = pc % 16, wi = pc % 2;
    if (m_nv[ni] && m_ntag[ni] == pc / 16) begin
      exp_v = 1; exp_t = (pc + m_noff[ni] + 65536) % 65536;
    end else if (m_wv[wi] && m_wtag[wi] == pc / 2) begin
      exp_v = 1; exp_t = m_wtgt[wi];
    end
    @(negedge clk);
    upd_valid = 0;
    lk_pc = pc[15:0];
    #1;
    chk({tag, " R2 R3 R4 R5 direction"}, int'(pred_taken), int'(m_dir[slot(pc)]));
    chk({tag, " R9 target valid"}, int'(pred_tgt_vld), exp_v);
    chk({tag, " R6 R7 R9 target"}, int'(pred_tgt), exp_t);
  endtask

  task automatic branch(input int pc, input bit tk, input int tg, input string tag);
    int s, g, d;
    expect_lookup(pc, tag);
    upd_valid = 1; upd_pc = pc[15:0]; upd_taken = tk; upd_target = tg[15:0];
    @(negedge clk);
    upd_valid = 0;
    s = slot(pc); g = s / 4;                 // R3 group of four
    if (m_dir[s] == tk) m_conf[g] = 1;
    else begin
      if (!m_conf[g]) m_dir[s] = tk;         // R4 flip only when unconfident
      m_conf[g] = 0;
    end
    m_hist = ((m_hist * 2) + int'(tk)) % 16; // R5
    if (tk) begin
      d = sdisp(pc, tg);
      if (d >= -32 && d <= 31) begin         // R6
        m_nv[pc % 16] = 1; m_ntag[pc % 16] = pc / 16; m_noff[pc % 16] = d;
        if (m_wtag[pc % 2] == pc / 2) m_wv[pc % 2] = 0;  // R8
      end else begin                         // R7
        m_wv[pc % 2] = 1; m_wtag[pc % 2] = pc / 2; m_wtgt[pc % 2] = tg;
        if (m_ntag[pc % 16] == pc / 16) m_nv[pc % 16] = 0; // R8
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_hist = 0;
    foreach (m_ntag[i]) begin m_ntag[i] = 0; m_noff[i] = 0; end
    foreach (m_wtag[i]) begin m_wtag[i] = 0; m_wtgt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state over every direction slot
    for (int p = 0; p < 64; p++) expect_lookup(p, "R1 reset");

    // R3 R4: confidence then a single miss keeps direction, second miss flips
    branch(12, 0, 0, "R3 conf");
    branch(12, 0, 0, "R3 conf");
    branch(12, 1, 12 + 4, "R4 keep");
    expect_lookup(13, "R4 keep");            // hist=1 -> same slot 12
    branch(40, 1, 44, "R4 flip");
    branch(41, 1, 45, "R4 flip");
    expect_lookup(41, "R4 flip");

    // R6 R7 R8: displacement boundaries and table handover
    branch(16'h0100, 1, 16'h0110, "R6 short +16");
    branch(16'h0200, 1, 16'h01E0, "R6 short -32");
    branch(16'h0210, 1, 16'h022F, "R6 short +31");
    branch(16'h0300, 1, 16'h0320, "R7 wide +32");
    branch(16'h0301, 1, 16'h02DF, "R7 wide -34");
    expect_lookup(16'h0200, "R6 boundary");
    expect_lookup(16'h0210, "R6 boundary");
    expect_lookup(16'h0300, "R7 wide");
    expect_lookup(16'h0301, "R7 wide");
    branch(16'h0300, 0, 16'h0999, "R8 not-taken");
    expect_lookup(16'h0300, "R8 not-taken unchanged");
    branch(16'h0300, 1, 16'h031F, "R8 wide to short");
    expect_lookup(16'h0300, "R8 evicted wide");
    branch(16'h0300, 1, 16'h8000, "R8 short to wide");
    expect_lookup(16'h0300, "R8 evicted short");
    expect_lookup(16'h0400, "R9 miss");

    // sweep: mixed outcomes, shared groups, aliasing and both tables
    for (int i = 0; i < 1500; i++) begin
      int pc = ((i % 29) * 4 + ((i / 29) % 3) * 16'h0040 + (i % 2)) % 65536;
      bit tk = ((i ^ (i >> 2) ^ (i >> 5)) & 1) != 0;
      int tg;
      case (i % 5)
        0: tg = pc + 16'h0400;
        1: tg = pc - ((i % 7) * 5);
        2: tg = pc + 31;
        3: tg = pc - 33;
        default: tg = pc + (i % 32);
      endcase
      branch(pc, tk, (tg + 65536) % 65536, "sweep");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule